// File: doc/BRIEF.md
# Debug Breakpoint and Watchpoint Match Unit

This block holds a bank of breakpoint comparators and a bank of watchpoint comparators. Each comparator has a control word and a value word. Every cycle the block checks the current fetch address and the per-slot watchpoint hit indications against the programmed slots. It reports whether a breakpoint or a watchpoint should raise a debug event, and which slot matched. Before a slot can match, it must pass a filter on the current privilege level and on the security state. A slot can also require a match on a linked context comparator. A linked comparator counts only when it sits inside the context-capable window, which is the top `NUM_CTX` breakpoint slots.

Control and value words are loaded through a one-cycle write strobe. The match results are registered. The unit also registers the faulting data address for a watchpoint, adjusted for byte-invariant big-endian lane order. Exception generation and address masking are left to the surrounding logic.

Top module: `dbgm_match_unit`

## Requirements
- R1: After reset `bp_hit`, `wp_hit`, `bp_idx`, `wp_idx` and `wp_addr_q` are all zero.
- R2: While `dbg_en` is low, neither `bp_hit` nor `wp_hit` is raised, even if a slot would otherwise match.
- R3: A breakpoint slot can match only when its control bit 0 (enable) is set and its value word equals `pc`. Control and value words are written when `cfg_we` is high: `cfg_wp` selects the bank (0 = breakpoint), `cfg_val` selects the word (1 = value), and `cfg_idx` selects the slot.
- R4: Privilege filter on the control word. Bit 1 permits a match at level 1. Bit 2 permits a match at level 0. Bit 13 permits a match at levels 2 and 3.
- R5: Security filter on control bits [15:14]. Code 0 matches in both states. Code 2 matches only when `secure` is high. Codes 1 and 3 match only when `secure` is low.
- R6: When control bit 20 is set, the slot also needs the breakpoint comparator named by bits [19:16] to pass as a context comparator. That comparator passes only if all of the following hold:
  - its index lies in [NUM_BP-NUM_CTX, NUM_BP-1];
  - its bit 0 is set;
  - its bits [23:20] equal 3;
  - `cur_el` is 0 or 1;
  - `ctx_id` equals the low CTX_W bits of its value word.
- R7: A watchpoint slot can match only when its enable bit 0 is set and its bit of `wp_raw` is high. When `wp_user` is high, the slot is filtered as if the level were 0, whatever `cur_el` is.
- R8: When several slots of one bank match, the lowest index is reported. The index output reads zero when its bank has no hit.
- R9: All match outputs appear one clock after the inputs that cause them.
- R10: `wp_addr_q` registers `wp_addr` every cycle. When `be_inv` is high, the registered address is XORed with 3 if `wp_len` is 0 (1 byte) and with 2 if `wp_len` is 1 (2 bytes). In every other case it is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wp | input | 1 | Bank select, 1 = watchpoint |
| cfg_val | input | 1 | Word select, 1 = value word, 0 = control word |
| cfg_idx | input | 4 | Slot index for the write |
| cfg_wdata | input | ADDR_W | Write data (control uses the low 32 bits) |
| dbg_en | input | 1 | Global debug match enable |
| cur_el | input | 2 | Current privilege level |
| secure | input | 1 | Current security state, 1 = secure |
| pc | input | ADDR_W | Current fetch address |
| wp_raw | input | NUM_WP | Per-slot watchpoint address hit |
| wp_user | input | 1 | Access carries the unprivileged attribute |
| ctx_id | input | CTX_W | Current context identifier |
| be_inv | input | 1 | Byte-invariant big-endian mode |
| wp_addr | input | ADDR_W | Data access address |
| wp_len | input | 2 | Access size code: 0 = 1 B, 1 = 2 B, 2 = 4 B, 3 = 8 B |
| bp_hit | output | 1 | Registered breakpoint match |
| bp_idx | output | 4 | Lowest matching breakpoint slot |
| wp_hit | output | 1 | Registered watchpoint match |
| wp_idx | output | 4 | Lowest matching watchpoint slot |
| wp_addr_q | output | ADDR_W | Registered, lane-adjusted data address |

## Verification
The bench targets the link window edges. A link to the slot just below the context window must fail even when that slot is programmed as a valid context comparator. A design that checks only the enable bit and the type would wrongly report a hit there. A linked comparator of the right type must also stop matching at level 2, even when the linking slot permits level 2. The bench also flips `wp_user` while the level is 1, which catches a filter that ignores the unprivileged attribute. It drives two matching slots at once; a priority encoder that scans in the wrong direction then returns the higher index. Finally it checks each access size in big-endian mode, so a swapped XOR constant shows up in `wp_addr_q`.

// File: rtl/dbgm_pkg.sv
`timescale 1ns/1ps
package dbgm_pkg;
   localparam int CTL_W = 32;
   localparam int IDX_W = 4;
   localparam logic [3:0] CTX_TYPE = 4'd3;

   typedef struct packed {
      logic       en;
      logic       el1_ok;
      logic       el0_ok;
      logic       hi_ok;
      logic [1:0] sec;
      logic [3:0] lnk;
      logic [3:0] typ;
   } ctl_f_t;

   function automatic ctl_f_t unpack_ctl(input logic [CTL_W-1:0] w);
      ctl_f_t f;
      f.en     = w[0];
      f.el1_ok = w[1];
      f.el0_ok = w[2];
      f.hi_ok  = w[13];
      f.sec    = w[15:14];
      f.lnk    = w[19:16];
      f.typ    = w[23:20];
      return f;
   endfunction

   function automatic logic priv_pass(input ctl_f_t f, input logic [1:0] el);
      case (el)
         2'd0:    return f.el0_ok;
         2'd1:    return f.el1_ok;
         default: return f.hi_ok;
      endcase
   endfunction

   function automatic logic sec_pass(input ctl_f_t f, input logic secure);
      case (f.sec)
         2'd0:    return 1'b1;
         2'd2:    return secure;
         default: return !secure;
      endcase
   endfunction
endpackage

// File: rtl/dbgm_cfg_bank.sv
`timescale 1ns/1ps
module dbgm_cfg_bank
   import dbgm_pkg::*;
#(
   parameter int N  = 4,
   parameter int DW = 32
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      we,
   input  logic                      sel_val,
   input  logic [IDX_W-1:0]          idx,
   input  logic [DW-1:0]             wdata,
   output logic [N-1:0][CTL_W-1:0]   ctl_o,
   output logic [N-1:0][DW-1:0]      val_o
);
   for (genvar s = 0; s < N; s++) begin : g_slot
      localparam logic [IDX_W-1:0] MY_IDX = IDX_W'(s);
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            ctl_o[s] <= '0;
            val_o[s] <= '0;
         end else if (we && idx == MY_IDX) begin
            if (sel_val) val_o[s] <= wdata;
            else         ctl_o[s] <= wdata[CTL_W-1:0];
         end
      end
   end
endmodule

// File: rtl/dbgm_ctx_unit.sv
`timescale 1ns/1ps
module dbgm_ctx_unit
   import dbgm_pkg::*;
#(
   parameter int NUM_BP  = 6,
   parameter int NUM_CTX = 2,
   parameter int ADDR_W  = 32,
   parameter int CTX_W   = 32
) (
   input  logic [NUM_BP-1:0][CTL_W-1:0]  bp_ctl,
   input  logic [NUM_BP-1:0][ADDR_W-1:0] bp_val,
   input  logic [1:0]                    cur_el,
   input  logic [CTX_W-1:0]              ctx_id,
   output logic [NUM_BP-1:0]             ctx_ok
);
   localparam int WIN_LO = NUM_BP - NUM_CTX;

   for (genvar k = 0; k < NUM_BP; k++) begin : g_cmp
      if (k >= WIN_LO) begin : g_live
         ctl_f_t f;
         assign f = unpack_ctl(bp_ctl[k]);
         assign ctx_ok[k] = f.en && (f.typ == CTX_TYPE) && (cur_el <= 2'd1)
                            && (ctx_id == bp_val[k][CTX_W-1:0]);
      end else begin : g_dead
         assign ctx_ok[k] = 1'b0;
      end
   end
endmodule

// File: rtl/dbgm_slot_qual.sv
`timescale 1ns/1ps
module dbgm_slot_qual
   import dbgm_pkg::*;
#(
   parameter int NUM_BP = 6
) (
   input  logic [CTL_W-1:0]  ctl,
   input  logic [1:0]        el,
   input  logic              secure,
   input  logic              raw,
   input  logic [NUM_BP-1:0] ctx_ok,
   output logic              match
);
   ctl_f_t f;
   logic   link_ok;

   assign f = unpack_ctl(ctl);

   always_comb begin
      link_ok = 1'b0;
      for (int j = 0; j < NUM_BP; j++) begin
         if (f.lnk == IDX_W'(j)) link_ok = ctx_ok[j];
      end
   end

   assign match = raw && f.en && priv_pass(f, el) && sec_pass(f, secure)
                  && (!f.typ[0] || link_ok);
endmodule

// File: rtl/dbgm_first_set.sv
`timescale 1ns/1ps
module dbgm_first_set
   import dbgm_pkg::*;
#(
   parameter int N = 4
) (
   input  logic [N-1:0]     req,
   output logic             found,
   output logic [IDX_W-1:0] idx
);
   always_comb begin
      found = 1'b0;
      idx   = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (req[i]) begin
            found = 1'b1;
            idx   = IDX_W'(i);
         end
      end
   end
endmodule

// File: rtl/dbgm_match_unit.sv
`timescale 1ns/1ps
module dbgm_match_unit
   import dbgm_pkg::*;
#(
   parameter int NUM_BP  = 6,
   parameter int NUM_WP  = 4,
   parameter int NUM_CTX = 2,
   parameter int ADDR_W  = 32,
   parameter int CTX_W   = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic              cfg_wp,
   input  logic              cfg_val,
   input  logic [3:0]        cfg_idx,
   input  logic [ADDR_W-1:0] cfg_wdata,
   input  logic              dbg_en,
   input  logic [1:0]        cur_el,
   input  logic              secure,
   input  logic [ADDR_W-1:0] pc,
   input  logic [NUM_WP-1:0] wp_raw,
   input  logic              wp_user,
   input  logic [CTX_W-1:0]  ctx_id,
   input  logic              be_inv,
   input  logic [ADDR_W-1:0] wp_addr,
   input  logic [1:0]        wp_len,
   output logic              bp_hit,
   output logic [3:0]        bp_idx,
   output logic              wp_hit,
   output logic [3:0]        wp_idx,
   output logic [ADDR_W-1:0] wp_addr_q
);
   localparam int MAX_SLOTS = 1 << IDX_W;

   if (NUM_BP < 1 || NUM_BP > MAX_SLOTS) begin : g_bad_bp
      $error("NUM_BP out of range");
   end
   if (NUM_WP < 1 || NUM_WP > MAX_SLOTS) begin : g_bad_wp
      $error("NUM_WP out of range");
   end
   if (NUM_CTX < 1 || NUM_CTX > NUM_BP) begin : g_bad_ctx
      $error("NUM_CTX must lie in 1..NUM_BP");
   end
   if (ADDR_W < CTL_W || CTX_W > ADDR_W) begin : g_bad_w
      $error("ADDR_W must hold a control word and a context id");
   end

   logic [NUM_BP-1:0][CTL_W-1:0]  bp_ctl;
   logic [NUM_BP-1:0][ADDR_W-1:0] bp_val;
   logic [NUM_WP-1:0][CTL_W-1:0]  wp_ctl;
   logic [NUM_WP-1:0][ADDR_W-1:0] wp_val_unused;
   logic [NUM_BP-1:0]             ctx_ok;
   logic [NUM_BP-1:0]             bp_match;
   logic [NUM_WP-1:0]             wp_match;
   logic                          bp_found, wp_found;
   logic [IDX_W-1:0]              bp_sel, wp_sel;
   logic [1:0]                    wp_el;
   logic [ADDR_W-1:0]             addr_adj;

   dbgm_cfg_bank #(.N(NUM_BP), .DW(ADDR_W)) u_bp_bank (
      .clk(clk), .rst_n(rst_n), .we(cfg_we && !cfg_wp), .sel_val(cfg_val),
      .idx(cfg_idx), .wdata(cfg_wdata), .ctl_o(bp_ctl), .val_o(bp_val));

   dbgm_cfg_bank #(.N(NUM_WP), .DW(ADDR_W)) u_wp_bank (
      .clk(clk), .rst_n(rst_n), .we(cfg_we && cfg_wp), .sel_val(cfg_val),
      .idx(cfg_idx), .wdata(cfg_wdata), .ctl_o(wp_ctl), .val_o(wp_val_unused));

   dbgm_ctx_unit #(.NUM_BP(NUM_BP), .NUM_CTX(NUM_CTX), .ADDR_W(ADDR_W), .CTX_W(CTX_W))
   u_ctx (.bp_ctl(bp_ctl), .bp_val(bp_val), .cur_el(cur_el), .ctx_id(ctx_id), .ctx_ok(ctx_ok));

   for (genvar b = 0; b < NUM_BP; b++) begin : g_bp
      dbgm_slot_qual #(.NUM_BP(NUM_BP)) u_q (
         .ctl(bp_ctl[b]), .el(cur_el), .secure(secure),
         .raw(bp_val[b] == pc), .ctx_ok(ctx_ok), .match(bp_match[b]));
   end

   assign wp_el = wp_user ? 2'd0 : cur_el;

   for (genvar w = 0; w < NUM_WP; w++) begin : g_wp
      dbgm_slot_qual #(.NUM_BP(NUM_BP)) u_q (
         .ctl(wp_ctl[w]), .el(wp_el), .secure(secure),
         .raw(wp_raw[w]), .ctx_ok(ctx_ok), .match(wp_match[w]));
   end

   dbgm_first_set #(.N(NUM_BP)) u_bp_pick (.req(bp_match), .found(bp_found), .idx(bp_sel));
   dbgm_first_set #(.N(NUM_WP)) u_wp_pick (.req(wp_match), .found(wp_found), .idx(wp_sel));

   always_comb begin
      addr_adj = wp_addr;
      if (be_inv) begin
         case (wp_len)
            2'd0:    addr_adj[1:0] = wp_addr[1:0] ^ 2'b11;
            2'd1:    addr_adj[1:0] = wp_addr[1:0] ^ 2'b10;
            default: addr_adj = wp_addr;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bp_hit    <= 1'b0;
         bp_idx    <= '0;
         wp_hit    <= 1'b0;
         wp_idx    <= '0;
         wp_addr_q <= '0;
      end else begin
         bp_hit    <= dbg_en && bp_found;
         bp_idx    <= (dbg_en && bp_found) ? bp_sel : '0;
         wp_hit    <= dbg_en && wp_found;
         wp_idx    <= (dbg_en && wp_found) ? wp_sel : '0;
         wp_addr_q <= addr_adj;
      end
   end
endmodule

// File: rtl/dbgm_match_chk.sv
`timescale 1ns/1ps
module dbgm_match_chk #(
   parameter int NUM_BP = 6,
   parameter int NUM_WP = 4,
   parameter int ADDR_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              dbg_en,
   input logic [NUM_WP-1:0] wp_raw,
   input logic              be_inv,
   input logic [ADDR_W-1:0] wp_addr,
   input logic              bp_hit,
   input logic [3:0]        bp_idx,
   input logic              wp_hit,
   input logic [3:0]        wp_idx,
   input logic [ADDR_W-1:0] wp_addr_q
);
   a_r2_off_no_hit: assert property (@(posedge clk) disable iff (!rst_n)
      !dbg_en |=> (!bp_hit && !wp_hit));

   a_r7_wp_needs_raw: assert property (@(posedge clk) disable iff (!rst_n)
      wp_hit |-> ((($past(wp_raw) >> wp_idx) & NUM_WP'(1)) != '0));

   a_r8_bp_idx_range: assert property (@(posedge clk) disable iff (!rst_n)
      bp_hit |-> (32'(bp_idx) < NUM_BP));

   a_r8_idle_idx_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (!bp_hit |-> bp_idx == '0) and (!wp_hit |-> wp_idx == '0));

   a_r10_le_addr_pass: assert property (@(posedge clk) disable iff (!rst_n)
      !be_inv |=> wp_addr_q == $past(wp_addr));
endmodule

bind dbgm_match_unit dbgm_match_chk #(.NUM_BP(NUM_BP), .NUM_WP(NUM_WP), .ADDR_W(ADDR_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .dbg_en(dbg_en), .wp_raw(wp_raw), .be_inv(be_inv),
   .wp_addr(wp_addr), .bp_hit(bp_hit), .bp_idx(bp_idx), .wp_hit(wp_hit),
   .wp_idx(wp_idx), .wp_addr_q(wp_addr_q));

// File: tb/test_dbgm_match_unit.sv
`timescale 1ns/1ps
module test_dbgm_match_unit;
   logic        clk = 0, rst_n = 0;
   logic        cfg_we = 0, cfg_wp = 0, cfg_val = 0;
   logic [3:0]  cfg_idx = 0;
   logic [31:0] cfg_wdata = 0;
   logic        dbg_en = 1, secure = 0, wp_user = 0, be_inv = 0;
   logic [1:0]  cur_el = 1, wp_len = 0;
   logic [31:0] pc = 0, ctx_id = 0, wp_addr = 0;
   logic [3:0]  wp_raw = 0;
   logic        bp_hit, wp_hit;
   logic [3:0]  bp_idx, wp_idx;
   logic [31:0] wp_addr_q;
   int n_tests = 0, n_fail = 0;

   always #2.5 clk = ~clk;

   dbgm_match_unit i_dbgm_match_unit (.*);

   task automatic check(string req, logic [31:0] act, logic [31:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [31:0] mk(bit en, bit [1:0] pac, bit hmc, bit [1:0] ssc,
                                      bit [3:0] lnk, bit [3:0] typ);
      return {8'h0, typ, lnk, ssc, hmc, 10'h0, pac, en};
   endfunction

   task automatic wr(bit wp, bit isval, int idx, logic [31:0] d);
      @(negedge clk);
      cfg_we = 1; cfg_wp = wp; cfg_val = isval; cfg_idx = 4'(idx); cfg_wdata = d;
      @(negedge clk);
      cfg_we = 0;
   endtask

   task automatic step;
      @(posedge clk); #1;
   endtask

   task automatic clear_all;
      for (int i = 0; i < 6; i++) wr(0, 0, i, 0);
      for (int i = 0; i < 4; i++) wr(1, 0, i, 0);
      dbg_en = 1; cur_el = 1; secure = 0; wp_user = 0; wp_raw = 0; be_inv = 0;
   endtask

   task automatic t_reset;
      check("R1 bp_hit", 32'(bp_hit), 0);
      check("R1 wp_hit", 32'(wp_hit), 0);
      check("R1 idx", {bp_idx, wp_idx}, 0);
      check("R1 addr", wp_addr_q, 0);
   endtask

   task automatic t_enable;
      clear_all();
      wr(0, 1, 0, 32'h0000_4000);
      wr(0, 0, 0, mk(1, 2'b11, 0, 0, 0, 0));
      pc = 32'h4000; dbg_en = 0; step();
      check("R2 gated", 32'(bp_hit), 0);
      dbg_en = 1; step();
      check("R3 hit", {bp_idx, 3'b0, bp_hit}, 32'h1);
      pc = 32'h4004; step();
      check("R3 pc mismatch", 32'(bp_hit), 0);
      pc = 32'h4000; wr(0, 0, 0, mk(0, 2'b11, 0, 0, 0, 0)); step();
      check("R3 disabled", 32'(bp_hit), 0);
   endtask

   task automatic t_priv;
      clear_all();
      wr(0, 1, 1, 32'h100); pc = 32'h100;
      wr(0, 0, 1, mk(1, 2'b01, 0, 0, 0, 0));
      cur_el = 1; step(); check("R4 el1 allowed", 32'(bp_hit), 1);
      cur_el = 0; step(); check("R4 el0 blocked", 32'(bp_hit), 0);
      cur_el = 2; step(); check("R4 el2 blocked", 32'(bp_hit), 0);
      wr(0, 0, 1, mk(1, 2'b10, 1, 0, 0, 0));
      cur_el = 3; step(); check("R4 el3 via bit13", 32'(bp_hit), 1);
      cur_el = 0; step(); check("R4 el0 via bit2", 32'(bp_hit), 1);
      cur_el = 1; step(); check("R4 el1 blocked", 32'(bp_hit), 0);
   endtask

   task automatic t_sec;
      clear_all();
      wr(0, 1, 2, 32'h200); pc = 32'h200;
      wr(0, 0, 2, mk(1, 2'b11, 0, 2'd1, 0, 0));
      secure = 1; step(); check("R5 code1 secure", 32'(bp_hit), 0);
      secure = 0; step(); check("R5 code1 nonsecure", 32'(bp_hit), 1);
      wr(0, 0, 2, mk(1, 2'b11, 0, 2'd2, 0, 0));
      step(); check("R5 code2 nonsecure", 32'(bp_hit), 0);
      secure = 1; step(); check("R5 code2 secure", 32'(bp_hit), 1);
      wr(0, 0, 2, mk(1, 2'b11, 0, 2'd3, 0, 0));
      step(); check("R5 code3 secure", 32'(bp_hit), 0);
      wr(0, 0, 2, mk(1, 2'b11, 0, 2'd0, 0, 0));
      step(); check("R5 code0 secure", 32'(bp_hit), 1);
   endtask

   task automatic t_link;
      clear_all();
      ctx_id = 32'hABCD_1234; pc = 32'h300;
      wr(0, 1, 4, 32'hABCD_1234); wr(0, 0, 4, mk(1, 0, 0, 0, 0, 4'd3));
      wr(0, 1, 3, 32'hABCD_1234); wr(0, 0, 3, mk(1, 0, 0, 0, 0, 4'd3));
      wr(0, 1, 1, 32'h300);       wr(0, 0, 1, mk(1, 2'b11, 1, 0, 4'd4, 4'd1));
      step(); check("R6 linked ctx match", {bp_idx, 3'b0, bp_hit}, 32'h11);
      ctx_id = 32'h1; step(); check("R6 ctx mismatch", 32'(bp_hit), 0);
      ctx_id = 32'hABCD_1234; cur_el = 2; step();
      check("R6 link fails at el2", 32'(bp_hit), 0);
      cur_el = 1; wr(0, 0, 1, mk(1, 2'b11, 1, 0, 4'd3, 4'd1)); step();
      check("R6 below window", 32'(bp_hit), 0);
      wr(0, 0, 1, mk(1, 2'b11, 1, 0, 4'd4, 4'd1));
      wr(0, 0, 4, mk(1, 0, 0, 0, 0, 4'd5)); step();
      check("R6 wrong type", 32'(bp_hit), 0);
      wr(0, 0, 4, mk(0, 0, 0, 0, 0, 4'd3)); step();
      check("R6 comparator disabled", 32'(bp_hit), 0);
   endtask

   task automatic t_wp;
      clear_all();
      wr(1, 0, 2, mk(1, 2'b10, 0, 0, 0, 0));
      wp_raw = 4'b0100; cur_el = 1; step();
      check("R7 el1 blocked", 32'(wp_hit), 0);
      wp_user = 1; step();
      check("R7 unprivileged as el0", {wp_idx, 3'b0, wp_hit}, 32'h21);
      wp_raw = 0; step();
      check("R7 no raw hit", 32'(wp_hit), 0);
   endtask

   task automatic t_prio;
      clear_all();
      pc = 32'h500;
      wr(0, 1, 0, 32'h500); wr(0, 0, 0, mk(1, 2'b11, 0, 0, 0, 0));
      wr(0, 1, 2, 32'h500); wr(0, 0, 2, mk(1, 2'b11, 0, 0, 0, 0));
      step(); check("R8 lowest bp", 32'(bp_idx), 0);
      check("R8 bp hit", 32'(bp_hit), 1);
      wr(0, 0, 0, 0); step(); check("R8 next bp", 32'(bp_idx), 2);
      wr(1, 0, 1, mk(1, 2'b11, 0, 0, 0, 0)); wr(1, 0, 3, mk(1, 2'b11, 0, 0, 0, 0));
      wp_raw = 4'b1010; step(); check("R8 lowest wp", 32'(wp_idx), 1);
      pc = 32'h504; #1; check("R9 holds before edge", 32'(bp_hit), 1);
      step(); check("R9 clears after edge", 32'(bp_hit), 0);
      check("R8 idx zero when idle", 32'(bp_idx), 0);
   endtask

   task automatic t_addr;
      wp_addr = 32'h1000_0010; be_inv = 1; wp_len = 0; step();
      check("R10 byte xor3", wp_addr_q, 32'h1000_0013);
      wp_len = 1; step(); check("R10 half xor2", wp_addr_q, 32'h1000_0012);
      wp_len = 2; step(); check("R10 word same", wp_addr_q, 32'h1000_0010);
      be_inv = 0; wp_len = 0; step(); check("R10 le same", wp_addr_q, 32'h1000_0010);
   endtask

   initial begin
      #1_000_000;
      n_fail++;
      $display("FAIL watchdog actual=running expected=done");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      #1; t_reset();
      repeat (2) @(negedge clk);
      rst_n = 1;
      t_enable();
      t_priv();
      t_sec();
      t_link();
      t_wp();
      t_prio();
      t_addr();
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule